// File: doc/BRIEF.md
# Synchronous Card Serial Command Front-End

This block is the three-wire serial front end of a synchronous memory card. The card side has a reset line, a slow serial clock and one open-drain data line. Both card lines are sampled on the fast system clock, and the block reacts to their rising and falling edges. The level of the card reset line sets the direction of the data line. While it is high, the block shifts in a 24-bit command word, least significant bit first. While it is low, the block either stays quiet or streams read data out, one bit per card clock.

Coming out of power-on, the block waits for a rising edge on the card reset line before it reacts to anything else. A short sequence of reset high, exactly one clock pulse and reset low is the answer-to-reset request, which streams the card contents from address 0. A full command word is decoded into an opcode, a 10-bit address and a data byte. Each accepted command pulses a one-cycle strobe on the memory-side outputs. Read commands stream bytes with an auto-incrementing address, either as 8 data bits or as 8 data bits followed by a protect bit.

A byte array with one protect bit per byte stands behind the front end and executes the write-type commands. After system reset, byte `a` holds `a[7:0] XOR 0xA5` and every protect bit is 1, meaning unprotected. The data line is modelled as an output enable plus a pull-low signal.

Top module: `card_fe`

## Requirements
- R1: After system reset the block is in the power-on state. `io_oe` stays 0, and no card clock pulse or falling card reset edge yields output or a command until the card reset line has risen.
- R2: A card reset rise, exactly one card clock rising edge, then a card reset fall starts a stream at address 0. Bit 0 of byte 0 is on the line right after the fall, and each byte goes out LSB first.
- R3: Whenever `card_rst` was high at the previous system clock edge, `io_oe` is 0, so the line is an input.
- R4: A command word is 24 bits, LSB first. Bits 0-5 are the control field with S0 first, bits 6-7 are address bits 8-9, bits 8-15 are address bits 0-7 and bits 16-23 are the data byte. The control field value, with S0 as bit 0, selects the command: 0x0E is an 8-bit read (op 0), 0x0C a 9-bit read (op 1), 0x33 a write (op 2), 0x31 a write with protect (op 3) and 0x30 a compare-and-protect (op 4). An accepted command pulses `cmd_valid` for one cycle with `cmd_op`, `cmd_addr` and `cmd_data`.
- R5: A command is accepted only if exactly 24 card clock rising edges arrive between the reset rise and the reset fall. Any other count except 1, and any control value not listed in R4, is discarded with no strobe and no memory change.
- R6: In an 8-bit read the address advances after every 8 card clocks, and it wraps from 1023 to 0.
- R7: In a 9-bit read each byte is followed by its protect bit, which reads 0 when the byte is protected and 1 when it is not. The address advances after every 9 card clocks.
- R8: Write-type commands (ops 2, 3 and 4) are discarded until a read has run since system reset. A read is either an answer-to-reset or a read command.
- R9: A card reset rise aborts an active read stream. It releases the line and restarts the command bit count.
- R10: A write stores the byte only if its protect bit is 1. A write with protect stores the byte in the same way and also clears the protect bit. A cleared protect bit never returns to 1.
- R11: A compare-and-protect clears the protect bit only when the command data equals the stored byte, and it never changes the byte.
- R12: `io_low` is high only while `io_oe` is high. A 1 bit leaves `io_low` at 0, so the line is released. The line value is `!(io_oe && io_low)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| card_rst | input | 1 | Card reset line; high selects command input |
| card_clk | input | 1 | Slow card serial clock |
| io_in | input | 1 | Sampled level of the data line |
| io_oe | output | 1 | Block is driving the data line |
| io_low | output | 1 | Pull the data line low |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_op | output | 3 | Decoded opcode (R4 encoding) |
| cmd_addr | output | 10 | Decoded byte address |
| cmd_data | output | 8 | Decoded data byte |

## Verification
Several rules are checked on every cycle by properties. The line is released whenever card reset was high, and `io_low` never asserts without `io_oe`. Every strobe follows a count of exactly 24 clocks, and no write-type strobe appears before a read. A reset rise always restarts the count, the bit index stays inside the byte-plus-protect frame, and protect bits only ever go from 1 to 0. Other behaviour can only be shown by the bench's scenarios: the bit order of commands and read data, the answer-to-reset sequence, the address stepping of 8-bit and 9-bit reads and the wrap at 1023, and the effect of protected, unprotected and mismatching writes on the array, read back through the line.

// File: rtl/card_fe_pkg.sv
package card_fe_pkg;

    localparam int CMD_BITS = 24;
    localparam int CTL_W    = 6;
    localparam int CNT_W    = $clog2(CMD_BITS + 2);

    localparam logic [CTL_W-1:0] CTL_RD8  = 6'h0E;
    localparam logic [CTL_W-1:0] CTL_RD9  = 6'h0C;
    localparam logic [CTL_W-1:0] CTL_WR   = 6'h33;
    localparam logic [CTL_W-1:0] CTL_WRP  = 6'h31;
    localparam logic [CTL_W-1:0] CTL_PCMP = 6'h30;

    typedef enum logic [2:0] {
        OP_RD8  = 3'd0,
        OP_RD9  = 3'd1,
        OP_WR   = 3'd2,
        OP_WRP  = 3'd3,
        OP_PCMP = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_POR,
        ST_IDLE,
        ST_SHIFT,
        ST_READ
    } st_e;

    typedef struct packed {
        logic known;
        op_e  op;
    } dec_t;

    function automatic dec_t decode_ctl(input logic [CTL_W-1:0] c);
        dec_t d;
        d.known = 1'b1;
        d.op    = OP_RD8;
        case (c)
            CTL_RD8:  d.op = OP_RD8;
            CTL_RD9:  d.op = OP_RD9;
            CTL_WR:   d.op = OP_WR;
            CTL_WRP:  d.op = OP_WRP;
            CTL_PCMP: d.op = OP_PCMP;
            default:  d.known = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic is_write(input op_e op);
        return (op == OP_WR) || (op == OP_WRP) || (op == OP_PCMP);
    endfunction

endpackage

// File: rtl/card_fe_edges.sv
module card_fe_edges (
    input  logic clk,
    input  logic rst,
    input  logic card_clk,
    input  logic card_rst,
    output logic clk_rise,
    output logic rst_rise,
    output logic rst_fall
);
    logic ck_q;
    logic rs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_q <= card_clk;
            rs_q <= card_rst;
        end else begin
            ck_q <= card_clk;
            rs_q <= card_rst;
        end
    end

    assign clk_rise = card_clk & ~ck_q;
    assign rst_rise = card_rst & ~rs_q;
    assign rst_fall = ~card_rst & rs_q;

endmodule

// File: rtl/card_fe_shifter.sv
module card_fe_shifter
    import card_fe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clk_rise,
    input  logic                rst_rise,
    input  logic                io_in,
    output logic [CMD_BITS-1:0] word,
    output logic [CNT_W-1:0]    count
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CMD_BITS + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            word  <= '0;
            count <= '0;
        end else if (rst_rise) begin
            count <= '0;
        end else if (clk_rise) begin
            word <= {io_in, word[CMD_BITS-1:1]};
            if (count != CNT_MAX)
                count <= count + 1'b1;
        end
    end

    // R9: a reset rise always restarts the count
    a_r9_count_restart: assert property (@(posedge clk) disable iff (rst)
        rst_rise |=> (count == '0));

    // R5: the count saturates just above a full word
    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_MAX);

endmodule

// File: rtl/card_fe_mem.sv
module card_fe_mem
    import card_fe_pkg::*;
#(
    parameter int          ADDR_W   = 10,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  INIT_XOR = 8'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  op_e               wr_op,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_prot
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] bytes [DEPTH];
    logic [DEPTH-1:0]  prot;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                bytes[i] <= DATA_W'(i) ^ DATA_W'(INIT_XOR);
            prot <= '1;
        end else if (wr_en) begin
            case (wr_op)
                OP_WR: begin
                    if (prot[wr_addr])
                        bytes[wr_addr] <= wr_data;
                end
                OP_WRP: begin
                    if (prot[wr_addr])
                        bytes[wr_addr] <= wr_data;
                    prot[wr_addr] <= 1'b0;
                end
                OP_PCMP: begin
                    if (bytes[wr_addr] == wr_data)
                        prot[wr_addr] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign rd_data = bytes[rd_addr];
    assign rd_prot = prot[rd_addr];

    // R10: protect bits are one-way
    a_r10_prot_one_way: assert property (@(posedge clk) disable iff (rst)
        $countones(prot) <= $past($countones(prot)));

endmodule

// File: rtl/card_fe_serial.sv
module card_fe_serial #(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      card_rst,
    input  logic                      streaming,
    input  logic [$clog2(DATA_W):0]   bit_idx,
    input  logic [DATA_W-1:0]         rd_data,
    input  logic                      rd_prot,
    output logic                      io_oe,
    output logic                      io_low
);
    localparam int IDX_W = $clog2(DATA_W);

    logic cur_bit;

    always_comb begin
        if (bit_idx == (IDX_W + 1)'(DATA_W))
            cur_bit = rd_prot;
        else
            cur_bit = rd_data[bit_idx[IDX_W-1:0]];
    end

    assign io_oe  = streaming;
    assign io_low = streaming & ~cur_bit;

    // R3: line is an input whenever card reset was high
    a_r3_input_when_rst_high: assert property (@(posedge clk) disable iff (rst)
        $past(card_rst) |-> !io_oe);

    // R12: never pull low without enabling the driver
    a_r12_low_needs_oe: assert property (@(posedge clk) disable iff (rst)
        io_low |-> io_oe);

endmodule

// File: rtl/card_fe_ctrl.sv
module card_fe_ctrl
    import card_fe_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clk_rise,
    input  logic                    rst_rise,
    input  logic                    rst_fall,
    input  logic [CMD_BITS-1:0]     word,
    input  logic [CNT_W-1:0]        count,
    output logic                    streaming,
    output logic [$clog2(DATA_W):0] bit_idx,
    output logic [ADDR_W-1:0]       rd_ptr,
    output logic                    cmd_valid,
    output op_e                     cmd_op,
    output logic [ADDR_W-1:0]       cmd_addr,
    output logic [DATA_W-1:0]       cmd_data
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W:0] LAST8 = (IDX_W + 1)'(DATA_W - 1);
    localparam logic [IDX_W:0] LAST9 = (IDX_W + 1)'(DATA_W);

    st_e               state;
    logic              nine;
    logic              read_done;
    dec_t              dec;
    logic [ADDR_W-1:0] w_addr;
    logic [DATA_W-1:0] w_data;
    logic              take_cmd;

    assign dec      = decode_ctl(word[CTL_W-1:0]);
    assign w_addr   = {word[CTL_W+1:CTL_W], word[CTL_W+2+7:CTL_W+2]};
    assign w_data   = word[CMD_BITS-1:CMD_BITS-DATA_W];
    assign take_cmd = (count == CNT_W'(CMD_BITS)) && dec.known &&
                      (!is_write(dec.op) || read_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_POR;
            nine      <= 1'b0;
            read_done <= 1'b0;
            bit_idx   <= '0;
            rd_ptr    <= '0;
            cmd_valid <= 1'b0;
            cmd_op    <= OP_RD8;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (rst_rise) begin
                state <= ST_SHIFT;
            end else begin
                case (state)
                    ST_SHIFT: begin
                        if (rst_fall) begin
                            if (count == CNT_W'(1)) begin
                                state     <= ST_READ;
                                rd_ptr    <= '0;
                                bit_idx   <= '0;
                                nine      <= 1'b0;
                                read_done <= 1'b1;
                            end else if (take_cmd) begin
                                cmd_valid <= 1'b1;
                                cmd_op    <= dec.op;
                                cmd_addr  <= w_addr;
                                cmd_data  <= w_data;
                                if (is_write(dec.op)) begin
                                    state <= ST_IDLE;
                                end else begin
                                    state     <= ST_READ;
                                    rd_ptr    <= w_addr;
                                    bit_idx   <= '0;
                                    nine      <= (dec.op == OP_RD9);
                                    read_done <= 1'b1;
                                end
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_READ: begin
                        if (clk_rise) begin
                            if (bit_idx == (nine ? LAST9 : LAST8)) begin
                                bit_idx <= '0;
                                rd_ptr  <= rd_ptr + 1'b1;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign streaming = (state == ST_READ);

    // R5: a strobe only follows exactly one full word of clocks
    a_r5_exact_count: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ($past(count) == CNT_W'(CMD_BITS)));

    // R8: no write-type strobe before a read has run
    a_r8_write_after_read: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && is_write(cmd_op)) |-> read_done);

    // R9: a reset rise leaves every other state for command capture
    a_r9_abort: assert property (@(posedge clk) disable iff (rst)
        rst_rise |=> (state == ST_SHIFT));

    // R6/R7: bit index stays within the byte or byte-plus-protect frame
    a_r6_index_range: assert property (@(posedge clk) disable iff (rst)
        streaming |-> (bit_idx <= (nine ? LAST9 : LAST8)));

endmodule

// File: rtl/card_fe.sv
module card_fe
    import card_fe_pkg::*;
#(
    parameter int         ADDR_W   = 10,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] INIT_XOR = 8'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              card_rst,
    input  logic              card_clk,
    input  logic              io_in,
    output logic              io_oe,
    output logic              io_low,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);
    localparam int IDX_W = $clog2(DATA_W);

    logic                clk_rise;
    logic                rst_rise;
    logic                rst_fall;
    logic [CMD_BITS-1:0] word;
    logic [CNT_W-1:0]    count;
    logic                streaming;
    logic [IDX_W:0]      bit_idx;
    logic [ADDR_W-1:0]   rd_ptr;
    logic [DATA_W-1:0]   rd_data;
    logic                rd_prot;
    op_e                 op_q;

    card_fe_edges u_edges (
        .clk      (clk),
        .rst      (rst),
        .card_clk (card_clk),
        .card_rst (card_rst),
        .clk_rise (clk_rise),
        .rst_rise (rst_rise),
        .rst_fall (rst_fall)
    );

    card_fe_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .clk_rise (clk_rise),
        .rst_rise (rst_rise),
        .io_in    (io_in),
        .word     (word),
        .count    (count)
    );

    card_fe_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .clk_rise  (clk_rise),
        .rst_rise  (rst_rise),
        .rst_fall  (rst_fall),
        .word      (word),
        .count     (count),
        .streaming (streaming),
        .bit_idx   (bit_idx),
        .rd_ptr    (rd_ptr),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_q),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data)
    );

    card_fe_mem #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .INIT_XOR (INIT_XOR)
    ) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmd_valid && is_write(op_q)),
        .wr_op   (op_q),
        .wr_addr (cmd_addr),
        .wr_data (cmd_data),
        .rd_addr (rd_ptr),
        .rd_data (rd_data),
        .rd_prot (rd_prot)
    );

    card_fe_serial #(
        .DATA_W (DATA_W)
    ) u_serial (
        .clk       (clk),
        .rst       (rst),
        .card_rst  (card_rst),
        .streaming (streaming),
        .bit_idx   (bit_idx),
        .rd_data   (rd_data),
        .rd_prot   (rd_prot),
        .io_oe     (io_oe),
        .io_low    (io_low)
    );

    assign cmd_op = op_q;

endmodule

// File: tb/card_fe_test.sv
module card_fe_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       card_rst = 1'b0;
    logic       card_clk = 1'b0;
    logic       io_in = 1'b0;
    logic       io_oe;
    logic       io_low;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic [9:0] cmd_addr;
    logic [7:0] cmd_data;

    int checks = 0;
    int errors = 0;
    int nvalid = 0;
    int bad_od = 0;
    logic [2:0] last_op;
    logic [9:0] last_addr;
    logic [7:0] last_data;

    always #2 clk = ~clk;

    card_fe uut (
        .clk       (clk),
        .rst       (rst),
        .card_rst  (card_rst),
        .card_clk  (card_clk),
        .io_in     (io_in),
        .io_oe     (io_oe),
        .io_low    (io_low),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data)
    );

    always @(posedge clk) begin
        if (!rst && cmd_valid) begin
            nvalid    <= nvalid + 1;
            last_op   <= cmd_op;
            last_addr <= cmd_addr;
            last_data <= cmd_data;
        end
        if (!rst && io_low && !io_oe)
            bad_od <= bad_od + 1;
    end

    typedef struct packed {
        logic [5:0] ctl;
        logic [9:0] adr;
        logic [7:0] dat;
        logic [4:0] ncl;
        logic       ev;
        logic [2:0] eop;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TABLE [NV] = '{
        '{6'h0E, 10'h00A, 8'h00, 5'd24, 1'b1, 3'd0},
        '{6'h0C, 10'h3FF, 8'h00, 5'd24, 1'b1, 3'd1},
        '{6'h33, 10'h020, 8'h3C, 5'd24, 1'b1, 3'd2},
        '{6'h33, 10'h021, 8'h11, 5'd23, 1'b0, 3'd0},
        '{6'h33, 10'h021, 8'h11, 5'd25, 1'b0, 3'd0},
        '{6'h3F, 10'h022, 8'h00, 5'd24, 1'b0, 3'd0},
        '{6'h31, 10'h040, 8'h77, 5'd24, 1'b1, 3'd3},
        '{6'h30, 10'h050, 8'h00, 5'd24, 1'b1, 3'd4},
        '{6'h30, 10'h051, 8'hF4, 5'd24, 1'b1, 3'd4},
        '{6'h33, 10'h040, 8'h00, 5'd24, 1'b1, 3'd2}
    };

    function automatic logic [7:0] init_byte(input logic [9:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_clk();
        @(negedge clk) card_clk = 1'b1;
        repeat (2) @(negedge clk);
        card_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_rst(input logic v);
        @(negedge clk) card_rst = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [5:0] ctl, input logic [9:0] adr,
                            input logic [7:0] dat, input int ncl);
        logic [23:0] w;
        w = {dat, adr[7:0], adr[9:8], ctl};
        set_rst(1'b1);
        for (int i = 0; i < ncl; i++) begin
            io_in = (i < 24) ? w[i] : 1'b0;
            pulse_clk();
        end
        io_in = 1'b0;
        set_rst(1'b0);
        @(negedge clk);
    endtask

    task automatic read_byte(input logic [7:0] exp, input bit nine, input bit expp, input string req);
        logic [8:0] got;
        logic [8:0] want;
        bit         oe_ok;
        got   = '0;
        oe_ok = 1'b1;
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            got[i] = io_oe ? ~io_low : 1'b1;
            if (!io_oe) oe_ok = 1'b0;
            pulse_clk();
        end
        want = {nine ? expp : 1'b0, exp};
        chk(oe_ok && (got == want), req, {22'd0, oe_ok, got}, {22'd0, 1'b1, want});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state and power-on quiet period
        chk(io_oe == 1'b0 && nvalid == 0, "R1 reset line released", {31'd0, io_oe}, 0);
        card_rst = 1'b1;
        repeat (2) @(negedge clk);
        card_rst = 1'b0;
        repeat (2) @(negedge clk);
        card_rst = 1'b1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        pulse_clk();
        pulse_clk();
        set_rst(1'b0);
        chk(io_oe == 1'b0 && nvalid == 0, "R1 no action before reset rise", {31'd0, io_oe}, 0);

        // R8: write before any read is discarded
        send_cmd(6'h33, 10'h003, 8'h00, 24);
        chk(nvalid == 0, "R8 write before read discarded", nvalid, 0);

        // R2: answer-to-reset streams from address 0
        set_rst(1'b1);
        pulse_clk();
        set_rst(1'b0);
        read_byte(init_byte(10'h000), 1'b0, 1'b0, "R2 answer-to-reset byte 0");
        read_byte(init_byte(10'h001), 1'b0, 1'b0, "R2 answer-to-reset byte 1");

        // R8: the discarded write left address 3 untouched
        send_cmd(6'h0E, 10'h003, 8'h00, 24);
        read_byte(init_byte(10'h003), 1'b0, 1'b0, "R8 address 3 unchanged");

        // R4/R5: table of command words
        for (int k = 0; k < NV; k++) begin
            v0 = nvalid;
            send_cmd(TABLE[k].ctl, TABLE[k].adr, TABLE[k].dat, int'(TABLE[k].ncl));
            if (TABLE[k].ev) begin
                chk(nvalid == v0 + 1, "R4 command strobe", nvalid - v0, 1);
                chk({last_op, last_addr, last_data} ==
                    {TABLE[k].eop, TABLE[k].adr, TABLE[k].dat},
                    "R4 decoded fields", {11'd0, last_op, last_addr, last_data},
                    {11'd0, TABLE[k].eop, TABLE[k].adr, TABLE[k].dat});
            end else begin
                chk(nvalid == v0, "R5 command discarded", nvalid - v0, 0);
            end
        end

        // R10: unprotected write, and discarded words left memory alone (R5)
        send_cmd(6'h0E, 10'h020, 8'h00, 24);
        read_byte(8'h3C, 1'b0, 1'b0, "R10 write stored");
        read_byte(init_byte(10'h021), 1'b0, 1'b0, "R5 short/long word no effect");
        read_byte(init_byte(10'h022), 1'b0, 1'b0, "R5 unknown code no effect");

        // R10/R7: write with protect, later write blocked
        send_cmd(6'h0C, 10'h040, 8'h00, 24);
        read_byte(8'h77, 1'b1, 1'b0, "R10 protected byte kept, protect bit 0");

        // R11/R7: compare mismatch leaves protect at 1, match clears it
        send_cmd(6'h0C, 10'h050, 8'h00, 24);
        read_byte(init_byte(10'h050), 1'b1, 1'b1, "R11 mismatch keeps protect bit");
        read_byte(init_byte(10'h051), 1'b1, 1'b0, "R7 next byte after 9 clocks, R11 match");

        // R6: wrap from 1023 to 0
        send_cmd(6'h0E, 10'h3FF, 8'h00, 24);
        read_byte(init_byte(10'h3FF), 1'b0, 1'b0, "R6 last address");
        read_byte(init_byte(10'h000), 1'b0, 1'b0, "R6 wrap to 0");

        // R9/R3: reset rise aborts a stream mid-byte
        send_cmd(6'h0E, 10'h010, 8'h00, 24);
        pulse_clk();
        pulse_clk();
        chk(io_oe == 1'b1, "R9 stream active before abort", {31'd0, io_oe}, 1);
        @(negedge clk) card_rst = 1'b1;
        @(negedge clk);
        chk(io_oe == 1'b0, "R3 line released while reset high", {31'd0, io_oe}, 0);
        @(negedge clk);
        set_rst(1'b0);
        chk(io_oe == 1'b0, "R9 aborted stream stays stopped", {31'd0, io_oe}, 0);

        // R12: open-drain discipline held throughout
        chk(bad_od == 0, "R12 low only with enable", bad_od, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule